// File: doc/BRIEF.md
# Configuration EEPROM Checksum Verifier

This block checks a 64-byte configuration image while it is streamed out of a serial EEPROM. A loader presents one byte at a time with its 6-bit location and a valid strobe. The bytes may come in any order. The block keeps two independent integrity checks and reports them once every location has been seen.

The first check covers the station-address area. Bytes 00h to 0Bh and bytes 0Eh and 0Fh are added into a 16-bit sum. That sum is compared with a 16-bit stored value held in the image itself: byte 0Ch is the low half and byte 0Dh the high half.

The second check covers the whole image. Every one of the 64 bytes, including the adjustment byte at 3Fh, is added modulo 256, and the result must come out at FFh. A start pulse clears all state so that a new image can be checked.

Top module: `cfg_image_checker`

## Requirements
- R1: After reset, and in the cycle after a cycle with `start_i` high, `done_o`, `addr_ok_o`, `image_ok_o` and `valid_o` are low and all sums and seen-location tracking are empty; `start_i` wins over a strobe in the same cycle, which is then not taken.
- R2: A byte is taken on a rising clock edge where `byte_vld_i` is high; `byte_addr_i` (00h to 3Fh) gives its location, and locations may arrive in any order.
- R3: A strobe to a location already taken since the last start or reset is ignored: its data changes neither check.
- R4: `done_o` goes high in the cycle after the edge that takes the last of the 64 distinct locations, and stays high until a start or reset.
- R5: While `done_o` is high, `addr_ok_o` is high exactly when the 16-bit sum of bytes 00h-0Bh, 0Eh and 0Fh equals {byte 0Dh, byte 0Ch}, with 0Dh the high byte.
- R6: While `done_o` is high, `image_ok_o` is high exactly when the sum of all 64 bytes modulo 256 equals FFh.
- R7: `valid_o` is high exactly when both `addr_ok_o` and `image_ok_o` are high.
- R8: While `done_o` is low, `addr_ok_o`, `image_ok_o` and `valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clears all state for a new image |
| byte_vld_i | input | 1 | Byte strobe |
| byte_addr_i | input | 6 | Location of the presented byte |
| byte_data_i | input | 8 | Value of the presented byte |
| done_o | output | 1 | All 64 locations taken |
| addr_ok_o | output | 1 | Station-address check passed |
| image_ok_o | output | 1 | Whole-image check passed |
| valid_o | output | 1 | Both checks passed |

## Verification
The bench loads good images in forward, reverse and strided orders. A design that assumed ascending addresses would then report done too early or sum the wrong bytes.

The station sum is built to exceed 255, so a design that kept it at 8 bits, or swapped the two stored bytes, fails a good image. Single corrupted bytes are used in three places: in the station area, in the stored sum, and in the adjust byte. A design that mixed up which bytes belong to which check reports the wrong flag.

Repeated strobes carry different data. A design that summed them again breaks both checks. A design that counted strobes instead of distinct locations raises done too early.

A start that arrives mid-load, or in the same cycle as a strobe, exposes stale sums or a byte taken that should have been dropped.

// File: rtl/cic_pkg.sv
// Package: shared sizes and byte-role helpers for the configuration image checker.
// Assumes a power-of-two image where the address width fixes the byte count.
package cic_pkg;
    localparam int unsigned ADDR_W    = 6;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned SUM_W     = 16;
    localparam int unsigned IMG_BYTES = 1 << ADDR_W;

    // Locations of the stored station sum and the end of the station area.
    localparam logic [ADDR_W-1:0] STORED_LO = 6'h0C;
    localparam logic [ADDR_W-1:0] STORED_HI = 6'h0D;
    localparam logic [ADDR_W-1:0] AREA_LAST = 6'h0F;
    localparam logic [DATA_W-1:0] IMG_TARGET = 8'hFF;

    typedef enum logic [1:0] {
        ROLE_OTHER   = 2'd0,
        ROLE_STATION = 2'd1,
        ROLE_SUM_LO  = 2'd2,
        ROLE_SUM_HI  = 2'd3
    } byte_role_e;

    // Classify a location by the part it plays in the station-address check.
    function automatic byte_role_e role_of(input logic [ADDR_W-1:0] a);
        if (a == STORED_LO)      return ROLE_SUM_LO;
        else if (a == STORED_HI) return ROLE_SUM_HI;
        else if (a <= AREA_LAST) return ROLE_STATION;
        else                     return ROLE_OTHER;
    endfunction
endpackage

// File: rtl/cic_seen_tracker.sv
// Seen-location tracker: one flag per image location. A strobe is accepted
// only the first time its location appears after a start or reset.
// Assumes start has priority over strobes. Done is the AND of all flags.
module cic_seen_tracker #(
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned NLOC  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              take_o,
    output logic              all_seen_o
);
    logic [NLOC-1:0] seen_q;

    // Accept a strobe only for a location not yet seen and not during start.
    assign take_o = vld_i && !start_i && !seen_q[addr_i];

    // One flag register per location, set by an accepted strobe to that location.
    for (genvar g = 0; g < NLOC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || start_i)
                seen_q[g] <= 1'b0;
            else if (take_o && addr_i == ADDR_W'(g))
                seen_q[g] <= 1'b1;
        end
    end

    assign all_seen_o = &seen_q;
endmodule

// File: rtl/cic_station_sum.sv
// Station-address check: adds the station bytes into a wide sum and captures
// the two stored-sum bytes. Assumes each location is presented once (see tracker).
module cic_station_sum #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              match_o
);
    import cic_pkg::*;

    logic [SUM_W-1:0]  acc_q;
    logic [DATA_W-1:0] lo_q, hi_q;
    byte_role_e        role;

    assign role = role_of(addr_i);

    // Accumulate station bytes, and capture the stored-sum halves.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            acc_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (take_i) begin
            unique case (role)
                ROLE_STATION: acc_q <= acc_q + SUM_W'(data_i);
                ROLE_SUM_LO:  lo_q  <= data_i;
                ROLE_SUM_HI:  hi_q  <= data_i;
                default:      ;
            endcase
        end
    end

    assign match_o = (acc_q == SUM_W'({hi_q, lo_q}));
endmodule

// File: rtl/cic_image_sum.sv
// Whole-image check: adds every accepted byte modulo 2**DATA_W and compares
// the result with the fixed target. Assumes each location arrives once.
module cic_image_sum #(
    parameter int unsigned DATA_W            = 8,
    parameter logic [DATA_W-1:0] TARGET      = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              match_o
);
    logic [DATA_W-1:0] acc_q;

    // Wrap-around accumulation of every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)
            acc_q <= '0;
        else if (take_i)
            acc_q <= acc_q + data_i;
    end

    assign match_o = (acc_q == TARGET);
endmodule

// File: rtl/cfg_image_checker.sv
// Configuration image checker top: routes each strobe through the seen-location
// tracker, feeds accepted bytes to both checks and gates the results with done.
// Assumes a synchronous active-low reset and a single-cycle start pulse.
module cfg_image_checker #(
    parameter int unsigned ADDR_W = cic_pkg::ADDR_W,
    parameter int unsigned DATA_W = cic_pkg::DATA_W,
    parameter int unsigned SUM_W  = cic_pkg::SUM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [5:0]        byte_addr_i,
    input  logic [7:0]        byte_data_i,
    output logic              done_o,
    output logic              addr_ok_o,
    output logic              image_ok_o,
    output logic              valid_o
);
    logic take, all_seen, st_match, img_match;

    cic_seen_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .vld_i(byte_vld_i), .addr_i(byte_addr_i),
        .take_o(take), .all_seen_o(all_seen)
    );

    cic_station_sum #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUM_W(SUM_W)) u_station (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .take_i(take),
        .addr_i(byte_addr_i), .data_i(byte_data_i), .match_o(st_match)
    );

    cic_image_sum #(.DATA_W(DATA_W), .TARGET(cic_pkg::IMG_TARGET)) u_image (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .take_i(take),
        .data_i(byte_data_i), .match_o(img_match)
    );

    // Results are meaningful only once every location has been taken.
    always_comb begin
        done_o     = all_seen;
        addr_ok_o  = all_seen && st_match;
        image_ok_o = all_seen && img_match;
        valid_o    = addr_ok_o && image_ok_o;
    end
endmodule

// File: rtl/cic_checker.sv
// Checker: temporal properties of the configuration image checker ports.
module cic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       byte_vld_i,
    input logic       done_o,
    input logic       addr_ok_o,
    input logic       image_ok_o,
    input logic       valid_o
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o); // R1
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(byte_vld_i)); // R2
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R4
    AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(addr_ok_o) && $stable(image_ok_o))); // R3
    AST_VALID_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (addr_ok_o && image_ok_o)); // R7
    AST_IDLE_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!addr_ok_o && !image_ok_o && !valid_o)); // R8
endmodule

bind cfg_image_checker cic_checker u_cic_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .done_o(done_o), .addr_ok_o(addr_ok_o), .image_ok_o(image_ok_o),
    .valid_o(valid_o)
);

// File: tb/test_cfg_image_checker.sv
module test_cfg_image_checker;
    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, byte_vld_i = 1'b0;
    logic [5:0] byte_addr_i = '0;
    logic [7:0] byte_data_i = '0;
    logic done_o, addr_ok_o, image_ok_o, valid_o;

    int n_run = 0, n_fail = 0;
    int img [64];
    bit m_seen [64];
    int m_data [64];
    int lcg = 12345;

    always #4 clk = ~clk; // 125 MHz

    cfg_image_checker i_cfg_image_checker (.*);

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Behavioural reference: expected outputs from the remembered bytes.
    task automatic compare();
        bit d = 1'b1;
        int ssum = 0, isum = 0;
        bit a, i;
        foreach (m_seen[k]) d &= m_seen[k];
        for (int k = 0; k < 16; k++)
            if (k != 12 && k != 13) ssum += m_data[k];
        foreach (m_data[k]) isum += m_data[k];
        a = d && ((ssum % 65536) == m_data[12] + 256 * m_data[13]);
        i = d && ((isum % 256) == 255);
        chk(done_o, d, "R4 done");
        chk(addr_ok_o, a, d ? "R5 addr_ok" : "R8 addr_ok");
        chk(image_ok_o, i, d ? "R6 image_ok" : "R8 image_ok");
        chk(valid_o, a && i, d ? "R7 valid" : "R8 valid");
    endtask

    task automatic model_clear();
        foreach (m_seen[k]) begin m_seen[k] = 1'b0; m_data[k] = 0; end
    endtask

    // One cycle: drive, clock, update the model, compare away from the edge.
    task automatic step(input bit st, input bit v, input int a, input int d);
        start_i = st; byte_vld_i = v; byte_addr_i = 6'(a); byte_data_i = 8'(d);
        @(posedge clk);
        if (!rst_n || st) model_clear();
        else if (v && !m_seen[a]) begin m_seen[a] = 1'b1; m_data[a] = d; end
        #2 compare();
    endtask

    function automatic int rnd();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >> 8) & 255;
    endfunction

    // Good image: stored sum in 0Ch/0Dh, adjust byte in 3Fh.
    task automatic make_good();
        int s = 0, t = 0;
        for (int k = 0; k < 64; k++) img[k] = rnd();
        for (int k = 0; k < 16; k++) if (k != 12 && k != 13) begin
            img[k] = 150 + (rnd() % 100); s += img[k];
        end
        img[12] = s % 256; img[13] = s / 256;
        for (int k = 0; k < 63; k++) t += img[k];
        img[63] = (255 - (t % 256) + 256) % 256;
    endtask

    task automatic load(input int order);
        for (int k = 0; k < 64; k++) begin
            int a = (order == 0) ? k : (order == 1) ? 63 - k : (k * 5) % 64;
            step(1'b0, 1'b1, a, img[a]);
        end
        step(1'b0, 1'b0, 0, 0);
    endtask

    task automatic fresh();
        step(1'b1, 1'b0, 0, 0);
    endtask

    initial begin
        #2;
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0, 0);
        chk(done_o, 1'b0, "R1 reset done");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 0, 0);
        chk(valid_o, 1'b0, "R1 idle valid");

        // In-order, reverse and strided good images (R2, R5, R6, R7).
        for (int o = 0; o < 3; o++) begin
            make_good(); fresh(); load(o);
            chk(valid_o, 1'b1, "R2 good image any order");
        end

        // Corrupt a station byte: only the station check fails (R5).
        make_good(); img[3] = (img[3] + 1) % 256; img[63] = (img[63] + 255) % 256;
        fresh(); load(0);
        chk(addr_ok_o, 1'b0, "R5 corrupt station"); chk(image_ok_o, 1'b1, "R6 still ok");

        // Stored high byte wrong (R5 16-bit compare, high half).
        make_good(); img[13] = (img[13] + 1) % 256; img[63] = (img[63] + 255) % 256;
        fresh(); load(1);
        chk(addr_ok_o, 1'b0, "R5 stored high byte");

        // Adjust byte wrong: only the image check fails (R6).
        make_good(); img[63] = (img[63] + 1) % 256;
        fresh(); load(2);
        chk(image_ok_o, 1'b0, "R6 bad adjust"); chk(addr_ok_o, 1'b1, "R5 unaffected");
        chk(valid_o, 1'b0, "R7 one fails");

        // Repeats with different data are ignored (R3); done waits for all 64 (R4).
        make_good(); fresh();
        for (int k = 0; k < 63; k++) begin
            step(1'b0, 1'b1, k, img[k]);
            step(1'b0, 1'b1, k, (img[k] + 7) % 256);
        end
        chk(done_o, 1'b0, "R4 not done at 63");
        step(1'b0, 1'b1, 63, img[63]);
        chk(done_o, 1'b1, "R4 done at 64");
        chk(valid_o, 1'b1, "R3 repeats ignored");
        step(1'b0, 1'b1, 3, 0);
        chk(valid_o, 1'b1, "R3 strobe after done ignored");

        // Start mid-load, then start with a strobe in the same cycle (R1).
        make_good(); fresh();
        for (int k = 0; k < 30; k++) step(1'b0, 1'b1, k, 200);
        step(1'b1, 1'b1, 5, img[5]);   // this strobe is dropped
        for (int k = 0; k < 64; k++) if (k != 5) step(1'b0, 1'b1, k, img[k]);
        chk(done_o, 1'b0, "R1 strobe with start dropped");
        step(1'b0, 1'b1, 5, img[5]);
        chk(valid_o, 1'b1, "R1 start cleared sums");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule